// File: doc/BRIEF.md
# Lockable CRT Display Timing Generator

This block generates raster timing for a CRT-style display. Two counters walk across every pixel position of a line and every line of a frame. Compare logic turns the count values into a display-enable strobe, a blanking signal, and raw active-high horizontal and vertical sync pulses. Sync polarity, pixel fetch and clock generation are handled elsewhere.

Software sets the raster geometry through a small register file that is written one word at a time. Each timing register carries a pair of boundaries, and every boundary is stored as its value minus one. A key register guards all configuration writes. Software writes the key, halts the generator through the enable bit, reprograms the geometry, restarts the generator, and then relocks the registers.

Top module: `crt_timing_gen`

## Requirements
- R1: After reset, both counters are 0, `disp_en`, `hsync` and `vsync` are 0, `blank` is 1, the block is locked, and every register reads as 0.
- R2: A write to offset 0x00 unlocks the block when the data equals 0x00004758. Any other value written there, zero included, locks it. Reading offset 0x00 returns the lock state in bit 0, where 1 means unlocked and all other bits are 0.
- R3: While the block is locked, writes to any offset other than 0x00 are ignored. Reads still return the stored values.
- R4: Bit 0 of offset 0x08 is the timing-enable bit. The horizontal timing registers are at 0x40 (active/total), 0x44 (blank start/end) and 0x48 (sync start/end). The vertical timing registers are at 0x50, 0x54 and 0x58 with the same pairs. In each timing register, bits 15:0 hold the first value minus one and bits 31:16 hold the second value minus one. Every register reads back what was written to it. Unmapped offsets read as 0 and ignore writes.
- R5: While enabled, `h_count` steps by one each cycle from 0 up to horizontal total minus one and then returns to 0. `v_count` advances by one only on that wrap, and it returns to 0 after vertical total minus one.
- R6: `disp_en` is 1 exactly when the block is enabled, `h_count` is below the horizontal active width, and `v_count` is below the vertical active height.
- R7: `blank` is 1 whenever either counter is at or beyond its blank start and below its blank end. It is also 1 whenever the block is disabled.
- R8: `hsync` is 1 when `h_count` is at or beyond horizontal sync start and below horizontal sync end. `vsync` follows the same rule using the vertical values.
- R9: In the first cycle after the enable bit is cleared, `disp_en`, `hsync` and `vsync` are 0. From the cycle after that, both counters hold at 0.
- R10: In the first cycle after the enable bit is set, both counters read 0, and counting proceeds from there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| h_count | output | 16 | Pixel position within the line |
| v_count | output | 16 | Line position within the frame |
| disp_en | output | 1 | Inside the visible area on both axes |
| blank | output | 1 | Blanking interval on either axis |
| hsync | output | 1 | Raw horizontal sync, active high |
| vsync | output | 1 | Raw vertical sync, active high |

## Verification
A counter that wraps one step early or late makes the frame period differ from total × lines. The bench's cycle-by-cycle model catches this within one line. An off-by-one in how the minus-one fields are decoded moves an edge of `blank`, `hsync` or `disp_en` by one pixel, and this shows up on the first line after enable. A lock state that is wrong appears either as a readback that did not change or as an enable bit that follows a write it should have ignored. The counters then move when they should not, or stay still when they should move, in the very next cycle.

// File: rtl/crt_tg_pkg.sv
package crt_tg_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int CNT_W  = DATA_W / 2;
  localparam int N_TIM  = 6;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h0000_4758;

  localparam logic [ADDR_W-1:0] A_LOCK = 8'h00;
  localparam logic [ADDR_W-1:0] A_CFG  = 8'h08;
  localparam logic [ADDR_W-1:0] A_HACT = 8'h40;
  localparam logic [ADDR_W-1:0] A_VACT = 8'h50;

  // One timing word: second boundary (minus one) high, first boundary low
  typedef struct packed {
    logic [CNT_W-1:0] hi_m1;
    logic [CNT_W-1:0] lo_m1;
  } span_t;

  typedef struct packed {
    span_t act;
    span_t blk;
    span_t syn;
  } axis_cfg_t;

  // Offset of timing word i: three horizontal words, then three vertical
  function automatic logic [ADDR_W-1:0] tim_addr(int i);
    if (i < 3) return A_HACT + ADDR_W'(4 * i);
    else       return A_VACT + ADDR_W'(4 * (i - 3));
  endfunction
endpackage

// File: rtl/crt_tg_regs.sv
module crt_tg_regs
  import crt_tg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              unlocked,
  output logic              tgen,
  output axis_cfg_t         h_cfg,
  output axis_cfg_t         v_cfg
);
  logic              unl_q, unl_d;
  logic              en_q, en_d;
  logic [DATA_W-1:0] tim_q [N_TIM];
  logic [DATA_W-1:0] tim_d [N_TIM];

  always_comb begin
    unl_d = unl_q;
    en_d  = en_q;
    tim_d = tim_q;
    if (we) begin
      if (addr == A_LOCK) begin
        unl_d = (wdata == UNLOCK_KEY);
      end else if (unl_q) begin
        if (addr == A_CFG) en_d = wdata[0];
        for (int i = 0; i < N_TIM; i++)
          if (addr == tim_addr(i)) tim_d[i] = wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unl_q <= 1'b0;
      en_q  <= 1'b0;
      for (int i = 0; i < N_TIM; i++) tim_q[i] <= '0;
    end else begin
      unl_q <= unl_d;
      en_q  <= en_d;
      for (int i = 0; i < N_TIM; i++) tim_q[i] <= tim_d[i];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_LOCK) rdata = DATA_W'(unl_q);
    if (addr == A_CFG)  rdata = DATA_W'(en_q);
    for (int i = 0; i < N_TIM; i++)
      if (addr == tim_addr(i)) rdata = tim_q[i];
  end

  assign unlocked = unl_q;
  assign tgen     = en_q;
  assign h_cfg    = {tim_q[0], tim_q[1], tim_q[2]};
  assign v_cfg    = {tim_q[3], tim_q[4], tim_q[5]};
endmodule

// File: rtl/crt_tg_counters.sv
module crt_tg_counters #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] h_last,
  input  logic [W-1:0] v_last,
  output logic [W-1:0] h_q,
  output logic [W-1:0] v_q
);
  logic [W-1:0] h_d, v_d;
  logic         h_wrap;

  assign h_wrap = (h_q >= h_last);

  always_comb begin
    h_d = h_q;
    v_d = v_q;
    if (!run) begin
      h_d = '0;
      v_d = '0;
    end else if (h_wrap) begin
      h_d = '0;
      v_d = (v_q >= v_last) ? '0 : v_q + 1'b1;
    end else begin
      h_d = h_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q <= '0;
      v_q <= '0;
    end else begin
      h_q <= h_d;
      v_q <= v_d;
    end
  end
endmodule

// File: rtl/crt_tg_axis.sv
module crt_tg_axis
  import crt_tg_pkg::*;
(
  input  logic [CNT_W-1:0] cnt,
  input  axis_cfg_t        cfg,
  output logic             in_act,
  output logic             in_blank,
  output logic             in_sync
);
  // Boundaries are stored minus one: cnt >= (x_m1 + 1) is cnt > x_m1,
  // and cnt < (x_m1 + 1) is cnt <= x_m1; no carry bit needed.
  assign in_act   = (cnt <= cfg.act.lo_m1);
  assign in_blank = (cnt > cfg.blk.lo_m1) && (cnt <= cfg.blk.hi_m1);
  assign in_sync  = (cnt > cfg.syn.lo_m1) && (cnt <= cfg.syn.hi_m1);
endmodule

// File: rtl/crt_timing_gen.sv
module crt_timing_gen
  import crt_tg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [CNT_W-1:0]  h_count,
  output logic [CNT_W-1:0]  v_count,
  output logic              disp_en,
  output logic              blank,
  output logic              hsync,
  output logic              vsync
);
  localparam int N_AXIS = 2;

  logic             rst_s1, rst_s2;
  logic             unlocked, tgen;
  axis_cfg_t        cfg [N_AXIS];
  logic [CNT_W-1:0] cnt [N_AXIS];
  logic [N_AXIS-1:0] in_act, in_blank, in_sync;

  // Reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  crt_tg_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_s2),
    .we       (reg_we),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .unlocked (unlocked),
    .tgen     (tgen),
    .h_cfg    (cfg[0]),
    .v_cfg    (cfg[1])
  );

  crt_tg_counters #(.W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_s2),
    .run    (tgen),
    .h_last (cfg[0].act.hi_m1),
    .v_last (cfg[1].act.hi_m1),
    .h_q    (cnt[0]),
    .v_q    (cnt[1])
  );

  for (genvar a = 0; a < N_AXIS; a++) begin : g_axis
    crt_tg_axis u_axis (
      .cnt      (cnt[a]),
      .cfg      (cfg[a]),
      .in_act   (in_act[a]),
      .in_blank (in_blank[a]),
      .in_sync  (in_sync[a])
    );
  end

  assign h_count = cnt[0];
  assign v_count = cnt[1];
  assign disp_en = tgen & (&in_act);
  assign blank   = ~tgen | (|in_blank);
  assign hsync   = tgen & in_sync[0];
  assign vsync   = tgen & in_sync[1];
endmodule

// File: rtl/crt_tg_chk.sv
module crt_tg_chk
  import crt_tg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              unlocked,
  input logic              tgen,
  input logic [CNT_W-1:0]  h_count,
  input logic [CNT_W-1:0]  v_count,
  input logic              disp_en,
  input logic              hsync,
  input logic              vsync
);
  // R2
  key_unlocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_LOCK && reg_wdata == UNLOCK_KEY) |=> unlocked);

  // R3
  locked_cfg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && reg_we && reg_addr != A_LOCK) |=> $stable(tgen));

  // R5
  v_moves_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tgen && $past(tgen) && h_count != '0) |-> $stable(v_count));

  // R9
  halt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tgen) |=> (h_count == '0 && v_count == '0));

  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tgen) |-> (!disp_en && !hsync && !vsync));
endmodule

bind crt_timing_gen crt_tg_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .unlocked  (unlocked),
  .tgen      (tgen),
  .h_count   (h_count),
  .v_count   (v_count),
  .disp_en   (disp_en),
  .hsync     (hsync),
  .vsync     (vsync)
);

// File: tb/crt_timing_gen_tb.sv
module crt_timing_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] h_count, v_count;
  logic        disp_en, blank, hsync, vsync;

  int n_chk = 0;
  int n_fail = 0;

  // Geometry: H active 4, front 2, sync 2, back 2 -> total 10
  //           V active 3, front 1, sync 1, back 1 -> total 6
  localparam int HA = 4, HSS = 6, HSE = 8, HT = 10;
  localparam int VA = 3, VSS = 4, VSE = 5, VT = 6;
  localparam logic [31:0] W_HACT = {16'(HT-1),  16'(HA-1)};
  localparam logic [31:0] W_HBLK = {16'(HT-1),  16'(HA-1)};
  localparam logic [31:0] W_HSYN = {16'(HSE-1), 16'(HSS-1)};
  localparam logic [31:0] W_VACT = {16'(VT-1),  16'(VA-1)};
  localparam logic [31:0] W_VBLK = {16'(VT-1),  16'(VA-1)};
  localparam logic [31:0] W_VSYN = {16'(VSE-1), 16'(VSS-1)};
  localparam logic [31:0] KEY = 32'h0000_4758;

  int hm, vm;

  crt_timing_gen u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .h_count(h_count),
    .v_count(v_count), .disp_en(disp_en), .blank(blank),
    .hsync(hsync), .vsync(vsync)
  );

  always #5 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic cmp_model();
    chk("R5 h_count", 32'(h_count), 32'(hm));
    chk("R5 v_count", 32'(v_count), 32'(vm));
    chk("R6 disp_en", 32'(disp_en), 32'(hm < HA && vm < VA));
    chk("R7 blank",   32'(blank),   32'(hm >= HA || vm >= VA));
    chk("R8 hsync",   32'(hsync),   32'(hm >= HSS && hm < HSE));
    chk("R8 vsync",   32'(vsync),   32'(vm >= VSS && vm < VSE));
  endtask

  task automatic step_model();
    @(negedge clk);
    if (hm == HT - 1) begin
      hm = 0;
      vm = (vm == VT - 1) ? 0 : vm + 1;
    end else hm++;
  endtask

  task automatic t_reset();
    chk("R1 h_count", 32'(h_count), 0);
    chk("R1 v_count", 32'(v_count), 0);
    chk("R1 outputs", {28'b0, disp_en, blank, hsync, vsync}, 32'b0100);
    rd_chk("R1 lock", 8'h00, 0);
    rd_chk("R1 cfg", 8'h08, 0);
    rd_chk("R1 hact", 8'h40, 0);
    rd_chk("R1 vsyn", 8'h58, 0);
  endtask

  task automatic t_wrong_key();
    wr(8'h00, 32'h0000_1234);
    rd_chk("R2 wrong key stays locked", 8'h00, 0);
    wr(8'h40, 32'hDEAD_BEEF);
    rd_chk("R3 locked write ignored", 8'h40, 0);
    wr(8'h08, 32'h1);
    rd_chk("R3 locked cfg ignored", 8'h08, 0);
    @(negedge clk);
    chk("R3 counter idle", 32'(h_count), 0);
  endtask

  task automatic t_program();
    wr(8'h00, KEY);
    rd_chk("R2 key unlocks", 8'h00, 1);
    wr(8'h40, W_HACT); wr(8'h44, W_HBLK); wr(8'h48, W_HSYN);
    wr(8'h50, W_VACT); wr(8'h54, W_VBLK); wr(8'h58, W_VSYN);
    rd_chk("R4 hact", 8'h40, W_HACT);
    rd_chk("R4 hblk", 8'h44, W_HBLK);
    rd_chk("R4 hsyn", 8'h48, W_HSYN);
    rd_chk("R4 vact", 8'h50, W_VACT);
    rd_chk("R4 vblk", 8'h54, W_VBLK);
    rd_chk("R4 vsyn", 8'h58, W_VSYN);
    wr(8'h4C, 32'hFFFF_FFFF);
    rd_chk("R4 unmapped", 8'h4C, 0);
    rd_chk("R4 hsyn untouched", 8'h48, W_HSYN);
  endtask

  task automatic t_run();
    wr(8'h08, 32'h1);
    hm = 0; vm = 0;
    chk("R10 start h", 32'(h_count), 0);
    chk("R10 start v", 32'(v_count), 0);
    for (int i = 0; i < 2 * HT * VT; i++) begin
      cmp_model();
      step_model();
    end
  endtask

  task automatic t_disable();
    repeat (5) @(negedge clk);
    wr(8'h08, 32'h0);
    chk("R9 disp_en off", 32'(disp_en), 0);
    chk("R9 hsync off", 32'(hsync), 0);
    chk("R9 vsync off", 32'(vsync), 0);
    chk("R7 blank when off", 32'(blank), 1);
    @(negedge clk);
    chk("R9 h held", 32'(h_count), 0);
    chk("R9 v held", 32'(v_count), 0);
    repeat (3) @(negedge clk);
    chk("R9 h still held", 32'(h_count), 0);
  endtask

  task automatic t_restart();
    wr(8'h08, 32'h1);
    chk("R10 restart h", 32'(h_count), 0);
    chk("R10 restart v", 32'(v_count), 0);
    @(negedge clk);
    chk("R10 first step", 32'(h_count), 1);
  endtask

  task automatic t_relock();
    wr(8'h00, 32'h0);
    rd_chk("R2 zero relocks", 8'h00, 0);
    wr(8'h08, 32'h0);
    rd_chk("R3 cfg kept", 8'h08, 1);
    hm = int'(h_count);
    @(negedge clk);
    chk("R3 still counting", 32'(h_count), 32'((hm + 1) % HT));
    wr(8'h40, 32'h0001_0001);
    rd_chk("R3 timing kept", 8'h40, W_HACT);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_wrong_key();
    t_program();
    t_run();
    t_disable();
    t_restart();
    t_relock();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule